// File: doc/BRIEF.md
# Video timing-code field delimiter

This block watches a byte-wide digital video stream, one byte per capture clock, and turns its embedded timing reference codes into two controls for a downstream capture engine, so that each video field can be stored in a buffer of its own. The first control, `start_o`, is a one-cycle pulse that marks a field boundary. The second, `stop_o`, is a level that a set code raises and a clear code lowers. A timing reference is the three-byte preamble 0xFF 0x00 0x00 followed by one code byte.

When it is enabled, the block starts out unlocked. It ignores every code until it sees the lock reference FF 00 00 EC. After that it is locked, and it reacts to four field codes until the enable is dropped or reset is applied. The outputs are registered, and the input byte is passed through on `data_o` with the same latency, so a capture engine sees each control next to the byte that completed it. This mode is meant only for a capture path that runs with 8-bit data.

Top module: `vtc_field_delimiter`

## Requirements
- R1: After a synchronous reset, and while `rst_i` is high, `start_o`, `stop_o`, `locked_o` and `data_o` are all 0. Reset from the locked state returns the block to the unlocked state.
- R2: While `en_i` is low, the block is held unlocked, with `start_o`, `stop_o` and `locked_o` all 0, and its preamble matcher is cleared. After `en_i` returns high, a field code gives no pulse until the lock reference is seen again.
- R3: When locked, the block drives `start_o` high for exactly one cycle when a reference FF 00 00 X completes with X equal to 0x9D, 0xDA, 0xF1 or 0xB6. The pulse appears in the cycle after the clock edge that samples X.
- R4: When unlocked, only FF 00 00 EC makes `locked_o` high, from the cycle after X is sampled. That reference produces no `start_o` pulse. Every other code, field codes included, leaves the block unlocked with `start_o` low.
- R5: When locked, FF 00 00 F1 sets `stop_o` and FF 00 00 B6 clears it, each from the cycle after X is sampled. `stop_o` is always 0 while the block is unlocked.
- R6: Once locked with `en_i` high, the block stays locked whatever bytes arrive. Codes that are not listed (for example 0xEC or 0x80) after FF 00 00 change neither `start_o` nor `stop_o`.
- R7: Overlapping preambles are found: any 0xFF byte restarts the matcher, so FF FF 00 00 X and FF 00 00 FF 00 00 X are recognised. A broken preamble such as FF 00 11 00 X is not recognised.
- R8: `data_o` equals the `data_i` byte sampled one clock earlier, so it lines up with `start_o` and `stop_o`.
- R9: A code byte counts only when it directly follows FF 00 00. The same value anywhere else in the stream has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, one byte per rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Mode enable; low holds the block unlocked |
| data_i | input | 8 | Incoming video stream byte |
| start_o | output | 1 | One-cycle field start pulse |
| stop_o | output | 1 | Stop level, set by code 0xF1 and cleared by code 0xB6 |
| locked_o | output | 1 | High once the lock reference has been seen |
| data_o | output | 8 | Input byte delayed to align with the controls |

## Verification
The unlocked state is swept over all 256 code values after a clean preamble. This separates the single lock code from every other value, including the four field codes, which must stay silent. The locked state is swept the same way over all 256 codes, each followed by active-video bytes, which separates the four pulse codes, the set code and the clear code from the unlisted codes. Directed streams cover repeated 0xFF bytes, a preamble that restarts inside another preamble, a broken preamble, and code values placed outside a preamble. Disable and reset applied in the locked state show that a field code cannot produce a pulse again until the block has relocked.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SYNC_HI    = 8'hFF;
    localparam byte_t SYNC_LO    = 8'h00;
    localparam byte_t CODE_LOCK  = 8'hEC;
    localparam byte_t CODE_FLD_A = 8'h9D;
    localparam byte_t CODE_FLD_B = 8'hDA;
    localparam byte_t CODE_OPEN  = 8'hF1;
    localparam byte_t CODE_CLOSE = 8'hB6;

    // Progress through the FF 00 00 preamble
    typedef enum logic [1:0] {
        PRE_IDLE = 2'd0,
        PRE_HI   = 2'd1,
        PRE_LO1  = 2'd2,
        PRE_LO2  = 2'd3
    } pre_stage_e;

    typedef enum logic {
        LK_SEEK = 1'b0,
        LK_MAIN = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic lock;      // lock reference seen
        logic field;     // code that pulses start
        logic stop_set;  // code that raises stop
        logic stop_clr;  // code that lowers stop
    } code_class_t;

    function automatic pre_stage_e pre_next(pre_stage_e cur, byte_t b);
        pre_stage_e nxt;
        if (b == SYNC_HI) begin
            nxt = PRE_HI;
        end else begin
            unique case (cur)
                PRE_HI:  nxt = (b == SYNC_LO) ? PRE_LO1 : PRE_IDLE;
                PRE_LO1: nxt = (b == SYNC_LO) ? PRE_LO2 : PRE_IDLE;
                default: nxt = PRE_IDLE;
            endcase
        end
        return nxt;
    endfunction

    function automatic code_class_t classify(byte_t b);
        code_class_t c;
        c.lock     = (b == CODE_LOCK);
        c.field    = (b == CODE_FLD_A) || (b == CODE_FLD_B) ||
                     (b == CODE_OPEN)  || (b == CODE_CLOSE);
        c.stop_set = (b == CODE_OPEN);
        c.stop_clr = (b == CODE_CLOSE);
        return c;
    endfunction

endpackage

// File: rtl/vtc_preamble_tracker.sv
module vtc_preamble_tracker
    import vtc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  clr_i,
    input  byte_t data_i,
    output logic  armed_o
);

    pre_stage_e stage_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            stage_q <= PRE_IDLE;
        end else begin
            stage_q <= pre_next(stage_q, data_i);
        end
    end

    // The current byte is the code byte after a full preamble
    assign armed_o = (stage_q == PRE_LO2) && !clr_i;

endmodule

// File: rtl/vtc_code_decoder.sv
module vtc_code_decoder
    import vtc_pkg::*;
(
    input  byte_t       data_i,
    input  logic        armed_i,
    output code_class_t cls_o
);

    code_class_t raw;

    always_comb begin
        raw   = classify(data_i);
        cls_o = armed_i ? raw : '0;
    end

endmodule

// File: rtl/vtc_lock_fsm.sv
module vtc_lock_fsm
    import vtc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        en_i,
    input  code_class_t cls_i,
    output logic        start_o,
    output logic        stop_o,
    output logic        locked_o
);

    lock_state_e state_q, state_d;
    logic        start_d, stop_d;

    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        stop_d  = stop_o;
        if (!en_i) begin
            state_d = LK_SEEK;
            stop_d  = 1'b0;
        end else begin
            unique case (state_q)
                LK_SEEK: begin
                    stop_d = 1'b0;
                    if (cls_i.lock) state_d = LK_MAIN;
                end
                LK_MAIN: begin
                    start_d = cls_i.field;
                    if (cls_i.stop_set)      stop_d = 1'b1;
                    else if (cls_i.stop_clr) stop_d = 1'b0;
                end
                default: state_d = LK_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= LK_SEEK;
            start_o <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            start_o <= start_d;
            stop_o  <= stop_d;
        end
    end

    assign locked_o = (state_q == LK_MAIN);

endmodule

// File: rtl/vtc_out_pipe.sv
module vtc_out_pipe #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_regs
            logic [WIDTH-1:0] r_q [DEPTH];
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    for (int i = 0; i < DEPTH; i++) r_q[i] <= '0;
                end else begin
                    r_q[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) r_q[i] <= r_q[i-1];
                end
            end
            assign q_o = r_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/vtc_field_delimiter.sv
module vtc_field_delimiter
    import vtc_pkg::*;
#(
    parameter int EXTRA_STAGES = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              locked_o,
    output logic [BYTE_W-1:0] data_o
);

    localparam int PIPE_W = BYTE_W + 3;

    logic        armed;
    code_class_t cls;
    logic        fsm_start, fsm_stop, fsm_locked;
    byte_t       data_q;

    vtc_preamble_tracker u_track (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (!en_i),
        .data_i  (data_i),
        .armed_o (armed)
    );

    vtc_code_decoder u_dec (
        .data_i  (data_i),
        .armed_i (armed),
        .cls_o   (cls)
    );

    vtc_lock_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .cls_i    (cls),
        .start_o  (fsm_start),
        .stop_o   (fsm_stop),
        .locked_o (fsm_locked)
    );

    // Data stage matching the control register stage
    always_ff @(posedge clk_i) begin
        if (rst_i) data_q <= '0;
        else       data_q <= data_i;
    end

    vtc_out_pipe #(
        .WIDTH (PIPE_W),
        .DEPTH (EXTRA_STAGES)
    ) u_pipe (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({fsm_start, fsm_stop, fsm_locked, data_q}),
        .q_o   ({start_o, stop_o, locked_o, data_o})
    );

endmodule

// File: rtl/vtc_field_delimiter_chk.sv
module vtc_field_delimiter_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic start,
    input logic stop,
    input logic locked
);

    p_disable_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!start && !stop && !locked));

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    p_start_after_lock_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(locked));

    p_lock_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> !start);

    p_stop_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
        stop |-> locked);

    p_lock_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && en) |=> locked);

endmodule

bind vtc_field_delimiter vtc_field_delimiter_chk u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .en     (en_i),
    .start  (fsm_start),
    .stop   (fsm_stop),
    .locked (fsm_locked)
);

// File: tb/vtc_field_delimiter_test.sv
module vtc_field_delimiter_test;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       en_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       start_o, stop_o, locked_o;
    logic [7:0] data_o;

    always #2 clk = ~clk;  // 250 MHz

    vtc_field_delimiter uut (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .data_i   (data_i),
        .start_o  (start_o),
        .stop_o   (stop_o),
        .locked_o (locked_o),
        .data_o   (data_o)
    );

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 0;
    logic rst_r = 1'b1;
    logic en_r  = 1'b0;

    // Reference model: the last three bytes seen while enabled
    logic [7:0] h0 = 8'h11, h1 = 8'h11, h2 = 8'h11;
    logic m_locked = 0, m_stop = 0, m_start = 0;
    logic [7:0] m_data = 0;

    task automatic model(input logic [7:0] b);
        logic hit;
        if (rst_r || !en_r) begin
            m_locked = 0; m_stop = 0; m_start = 0;
            h0 = 8'h11; h1 = 8'h11; h2 = 8'h11;
        end else begin
            hit = (h2 == 8'hFF) && (h1 == 8'h00) && (h0 == 8'h00);
            m_start = hit && m_locked &&
                      (b == 8'h9D || b == 8'hDA || b == 8'hF1 || b == 8'hB6);
            if (hit && m_locked && b == 8'hF1) m_stop = 1;
            if (hit && m_locked && b == 8'hB6) m_stop = 0;
            if (hit && !m_locked && b == 8'hEC) m_locked = 1;
            h2 = h1; h1 = h0; h0 = b;
        end
        m_data = rst_r ? 8'h00 : b;
    endtask

    task automatic step(input logic [7:0] b, input string tag);
        @(negedge clk);
        data_i = b; en_i = en_r; rst_i = rst_r;
        model(b);
        @(posedge clk);
        #1;
        vectors++;
        if (start_o !== m_start || stop_o !== m_stop || locked_o !== m_locked) begin
            fails++;
            $display("FAIL %s byte %02h: start/stop/locked got %b%b%b exp %b%b%b",
                     tag, b, start_o, stop_o, locked_o, m_start, m_stop, m_locked);
        end else if (data_o !== m_data) begin
            fails++;
            $display("FAIL R8 byte %02h: data_o got %02h exp %02h", b, data_o, m_data);
        end
    endtask

    task automatic ref4(input logic [7:0] code, input string tag);
        step(8'hFF, tag); step(8'h00, tag); step(8'h00, tag); step(code, tag);
    endtask

    initial begin
        // R1: reset state
        rst_r = 1; en_r = 1;
        step(8'h5A, "R1"); step(8'hFF, "R1");
        rst_r = 0;

        // R2: disabled, codes ignored
        en_r = 0;
        ref4(8'hEC, "R2"); ref4(8'h9D, "R2"); ref4(8'hF1, "R2");

        // R4: unlocked sweep over every code value, disable after each
        for (int v = 0; v < 256; v++) begin
            en_r = 1;
            ref4(v[7:0], "R4");
            en_r = 0;
            step(8'h00, "R2");
        end

        // R3 R5 R6: locked sweep over every code value
        en_r = 1;
        ref4(8'hEC, "R4");
        for (int v = 0; v < 256; v++) begin
            ref4(v[7:0], "R3_R5_R6");
            step(8'h10, "R3"); step(8'h80, "R6");
        end
        ref4(8'hB6, "R5"); step(8'h10, "R5");
        ref4(8'hF1, "R5"); ref4(8'hEC, "R6"); ref4(8'h80, "R6");
        ref4(8'hB6, "R5");

        // R7: overlapping and broken preambles
        step(8'hFF, "R7"); ref4(8'h9D, "R7");
        step(8'hFF, "R7"); step(8'h00, "R7"); ref4(8'hDA, "R7");
        step(8'hFF, "R7"); step(8'h00, "R7"); step(8'h00, "R7"); ref4(8'hF1, "R7");
        step(8'hFF, "R7"); step(8'h00, "R7"); step(8'h11, "R7");
        step(8'h00, "R7"); step(8'hB6, "R7");
        step(8'hFF, "R7"); step(8'h00, "R7"); step(8'h00, "R7");
        step(8'hFF, "R7"); step(8'hB6, "R7");

        // R9: code values outside a preamble
        step(8'h00, "R9"); step(8'h00, "R9"); step(8'hB6, "R9");
        step(8'h00, "R9"); step(8'h9D, "R9"); step(8'hFF, "R9");
        step(8'h00, "R9"); step(8'hDA, "R9");

        // R2: disable while locked, then a field code without relock
        en_r = 0; step(8'h00, "R2");
        en_r = 1; ref4(8'h9D, "R2"); ref4(8'hF1, "R2");
        ref4(8'hEC, "R4"); ref4(8'hF1, "R5");

        // R1: reset while locked, no pulse before relock
        rst_r = 1; step(8'h00, "R1");
        rst_r = 0; ref4(8'hDA, "R1"); ref4(8'hEC, "R1"); ref4(8'hDA, "R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule